// File: doc/BRIEF.md
# Converter Serial Readout Port

This block is the digital half of a 16-bit sampling converter's serial port. A host drives three pins: a convert strobe, a serial clock and a serial input. The block sends the conversion result out on one serial data line with an output-enable. The analog conversion itself is not modelled. A parallel result word and a one-cycle done strobe from outside stand in for it. All pins are sampled by a fast system clock, and the block acts on the pin edges it sees in those samples.

Each rising edge of the convert pin starts a conversion and fixes the operating style for the frame. If the serial input was high just before that edge, the port runs in select mode. The data line is then driven only while the part is addressed, which suits both three- and four-pin hookups. If the serial input was low, the port runs in cascade mode. In cascade mode the output register acts as a shift register that takes bits from the serial input behind the local word, so several converters can share one line. Either mode can emit a leading busy/start bit. Select mode arms it from the pin levels when the conversion finishes. Cascade mode arms it from the serial clock level at the convert edge. After each conversion the block drops its conversion-active flag, which models the automatic power-down.

Top module: `adc_serial_port`

## Requirements
- R1: At a convert-pin rise, the serial input's level in the sample before the edge picks the mode: 1 selects select mode and 0 selects cascade mode.
- R2: When the serial input and the convert pin rise in the same sample, as they do when the two pins are tied, cascade mode is chosen.
- R3: The result is sent MSB first. Each serial-clock falling edge moves the next bit onto `sdo` two system clocks after the pin change.
- R4: In cascade mode the serial input is captured at each serial-clock rise. The captured bits come out on `sdo` in order once the 16 local bits are done.
- R5: In select mode `sdo_oe` is 1 unless both the convert pin and the serial input are high. In cascade mode `sdo_oe` is always 1. Either way it follows the pins after two system clocks.
- R6: In select mode the start bit is armed if the convert pin or the serial input is low when `conv_done` arrives. `sdo` is then 1 in the next cycle, and the first serial-clock fall brings out the MSB.
- R7: When no start bit is armed, `sdo` shows the MSB in the cycle after `conv_done`.
- R8: In cascade mode the start bit is armed when the serial clock is high at the convert-pin rise.
- R9: `sdo` is 0 while a conversion is in progress.
- R10: `conv_busy` rises two clocks after a convert-pin rise and falls in the cycle after `conv_done`. A `conv_done` that arrives while `conv_busy` is 0 changes nothing.
- R11: While `rst` is high, `sdo`, `sdo_oe` and `conv_busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnv | input | 1 | Convert pin; its rise starts a conversion and latches the mode |
| sck | input | 1 | Serial clock pin |
| sdi | input | 1 | Serial input: mode select, readback select, or cascade data |
| conv_done | input | 1 | One-cycle end-of-conversion strobe |
| conv_data | input | DATA_W | Conversion result, taken at `conv_done` |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo` (0 means high impedance) |
| conv_busy | output | 1 | Conversion in progress |

## Verification
A pin change passes through one sampling register and one action register. The effects of `cnv`, `sck` and `sdi` are therefore due two system clocks after the change, and the effects of `conv_done` one clock after it. The bench drives inputs on falling clock edges. It waits three falling edges after each pin change and one after `conv_done` before it samples. Each check then lands after the result has settled and before the next stimulus. For cascade frames the bench computes the stream that should appear on `sdo`: the local word followed by the upstream word, shifted by one position when a start bit leads the frame.

// File: rtl/adc_if_pkg.sv
package adc_if_pkg;
  typedef enum logic {
    MODE_SELECT  = 1'b0,
    MODE_CASCADE = 1'b1
  } port_mode_t;
endpackage

// File: rtl/adc_pin_sampler.sv
module adc_pin_sampler #(
  parameter int NPINS = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pins,
  output logic [NPINS-1:0] cur,
  output logic [NPINS-1:0] prev
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        cur[i]  <= 1'b0;
        prev[i] <= 1'b0;
      end else begin
        cur[i]  <= pins[i];
        prev[i] <= cur[i];
      end
    end
  end
endmodule

// File: rtl/adc_mode_ctrl.sv
module adc_mode_ctrl
  import adc_if_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cnv_q,
  input  logic       cnv_rise,
  input  logic       sdi_q,
  input  logic       sdi_prev,
  input  logic       sck_q,
  input  logic       conv_done,
  output port_mode_t mode_o,
  output logic       conv_busy_o,
  output logic       load_o,
  output logic       busy_sel_o,
  output logic       oe_o
);
  logic cascade_busy;

  assign load_o     = conv_done && conv_busy_o && !cnv_rise;
  assign busy_sel_o = (mode_o == MODE_SELECT) ? (!cnv_q || !sdi_q) : cascade_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o       <= MODE_SELECT;
      cascade_busy <= 1'b0;
      conv_busy_o  <= 1'b0;
      oe_o         <= 1'b0;
    end else begin
      if (cnv_rise) begin
        mode_o       <= sdi_prev ? MODE_SELECT : MODE_CASCADE;
        cascade_busy <= sck_q;
        conv_busy_o  <= 1'b1;
      end else if (load_o) begin
        conv_busy_o  <= 1'b0;
      end
      oe_o <= (mode_o == MODE_CASCADE) || !(cnv_q && sdi_q);
    end
  end

  p_done_ends_r10: assert property (@(posedge clk) disable iff (rst)
    (conv_done && conv_busy_o && !cnv_rise) |=> !conv_busy_o);

  p_cascade_oe_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_o == MODE_CASCADE) |=> oe_o);
endmodule

// File: rtl/adc_out_shift.sv
module adc_out_shift #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              load,
  input  logic              busy_sel,
  input  logic              cascade,
  input  logic              conv_busy,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              sdi_q,
  input  logic [DATA_W-1:0] data,
  output logic              sdo
);
  localparam int MSB = DATA_W - 1;

  logic [MSB:0] sh;
  logic         cap;
  logic         pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      cap  <= 1'b0;
      pend <= 1'b0;
      sdo  <= 1'b0;
    end else if (start) begin
      pend <= 1'b0;
      sdo  <= 1'b0;
    end else if (load) begin
      sh <= data;
      if (busy_sel) begin
        pend <= 1'b1;
        sdo  <= 1'b1;
      end else begin
        pend <= 1'b0;
        sdo  <= data[MSB];
      end
    end else if (!conv_busy) begin
      if (sck_rise) cap <= cascade && sdi_q;
      if (sck_fall) begin
        if (pend) begin
          pend <= 1'b0;
          sdo  <= sh[MSB];
        end else begin
          sh  <= {sh[MSB-1:0], cap};
          sdo <= sh[MSB-1];
        end
      end
    end
  end

  p_idle_done_r10: assert property (@(posedge clk) disable iff (rst)
    (!conv_busy && !load && !start && !sck_fall) |=> $stable(sdo));
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_if_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnv,
  input  logic              sck,
  input  logic              sdi,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              conv_busy
);
  localparam int PIN_CNV = 0;
  localparam int PIN_SCK = 1;
  localparam int PIN_SDI = 2;
  localparam int NPINS   = 3;

  logic [NPINS-1:0] pin_cur, pin_prev;
  logic             cnv_rise, sck_rise, sck_fall;
  logic             load, busy_sel;
  port_mode_t       mode;

  adc_pin_sampler #(.NPINS(NPINS)) u_pins (
    .clk (clk),
    .rst (rst),
    .pins({sdi, sck, cnv}),
    .cur (pin_cur),
    .prev(pin_prev)
  );

  assign cnv_rise = pin_cur[PIN_CNV] && !pin_prev[PIN_CNV];
  assign sck_rise = pin_cur[PIN_SCK] && !pin_prev[PIN_SCK];
  assign sck_fall = !pin_cur[PIN_SCK] && pin_prev[PIN_SCK];

  adc_mode_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cnv_q      (pin_cur[PIN_CNV]),
    .cnv_rise   (cnv_rise),
    .sdi_q      (pin_cur[PIN_SDI]),
    .sdi_prev   (pin_prev[PIN_SDI]),
    .sck_q      (pin_cur[PIN_SCK]),
    .conv_done  (conv_done),
    .mode_o     (mode),
    .conv_busy_o(conv_busy),
    .load_o     (load),
    .busy_sel_o (busy_sel),
    .oe_o       (sdo_oe)
  );

  adc_out_shift #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .start    (cnv_rise),
    .load     (load),
    .busy_sel (busy_sel),
    .cascade  (mode == MODE_CASCADE),
    .conv_busy(conv_busy),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .sdi_q    (pin_cur[PIN_SDI]),
    .data     (conv_data),
    .sdo      (sdo)
  );

  p_sdo_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    conv_busy |-> !sdo);

  p_start_bit_r6: assert property (@(posedge clk) disable iff (rst)
    (load && busy_sel) |=> sdo);
endmodule

// File: tb/adc_serial_port_test.sv
module adc_serial_port_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cnv = 1'b0, sck = 1'b0, sdi = 1'b0, conv_done = 1'b0;
  logic [W-1:0] conv_data = '0;
  logic         sdo, sdo_oe, conv_busy;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  adc_serial_port #(.DATA_W(W)) uut (
    .clk(clk), .rst(rst), .cnv(cnv), .sck(sck), .sdi(sdi),
    .conv_done(conv_done), .conv_data(conv_data),
    .sdo(sdo), .sdo_oe(sdo_oe), .conv_busy(conv_busy)
  );

  // {select_mode, busy, data}
  localparam logic [17:0] VEC [0:7] = '{
    {1'b1, 1'b0, 16'hA5C3}, {1'b1, 1'b0, 16'h0F01},
    {1'b1, 1'b1, 16'h8001}, {1'b1, 1'b1, 16'h3C96},
    {1'b0, 1'b0, 16'hB2E7}, {1'b0, 1'b0, 16'h4001},
    {1'b0, 1'b1, 16'hD00D}, {1'b0, 1'b1, 16'h7FFE}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic cs, input logic busy, input logic [W-1:0] d);
    logic [W-1:0]   up;
    logic [2*W-1:0] stream;
    int             off, nf;
    up     = ~d ^ 16'h5A5A;
    stream = cs ? {d, {W{1'b0}}} : {d, up};
    off    = busy ? 1 : 0;
    nf     = cs ? (W - 1 + off) : (2 * W - 1 + off);
    cnv = 1'b0; sdi = cs; sck = (!cs && busy); tick(3);
    cnv = 1'b1; tick(3);
    check("R10 busy set", conv_busy, 1);
    if (cs) begin
      if (busy) begin
        cnv = 1'b0; tick(3);
        check("R5 select oe", sdo_oe, 1);
        check("R9 sdo low", sdo, 0);
      end else begin
        check("R1/R5 select mode oe off", sdo_oe, 0);
      end
    end else begin
      check("R1/R5 cascade oe", sdo_oe, 1);
      if (busy) begin sck = 1'b0; tick(3); end
      check("R9 sdo low", sdo, 0);
    end
    conv_data = d; conv_done = 1'b1; tick(1); conv_done = 1'b0;
    check("R10 busy clear", conv_busy, 0);
    if (busy) check(cs ? "R6 start bit" : "R8 start bit", sdo, 1);
    else      check("R7 msb at done", sdo, d[W-1]);
    if (cs && !busy) begin
      cnv = 1'b0; tick(3);
      check("R5 oe on", sdo_oe, 1);
      check("R7 msb", sdo, d[W-1]);
    end
    for (int j = 1; j <= nf; j++) begin
      int idx;
      idx = W - j + off;
      if (!cs) sdi = (idx >= 0 && idx < W) ? up[idx] : 1'b0;
      tick(3); sck = 1'b1; tick(3); sck = 1'b0; tick(3);
      check(cs ? "R3 bit" : "R4 stream", sdo, stream[2*W-1-(j-off)]);
    end
    cnv = 1'b0; sck = 1'b0; tick(3);
  endtask

  initial begin
    tick(4);
    check("R11 sdo", sdo, 0);
    check("R11 oe", sdo_oe, 0);
    check("R11 busy", conv_busy, 0);
    rst = 1'b0; tick(3);

    for (int v = 0; v < 8; v++)
      run_frame(VEC[v][17], VEC[v][16], VEC[v][15:0]);

    // R2: tied pins rise together -> cascade, oe stays on though both high
    cnv = 1'b0; sdi = 1'b0; tick(3);
    cnv = 1'b1; sdi = 1'b1; tick(3);
    check("R2 tied -> cascade oe", sdo_oe, 1);
    conv_data = 16'h1234; conv_done = 1'b1; tick(1); conv_done = 1'b0;
    check("R2 busy clear", conv_busy, 0);
    cnv = 1'b0; sdi = 1'b0; tick(3);

    // four-pin select: cnv held high, sdi used as readback select
    sdi = 1'b1; tick(3);
    cnv = 1'b1; tick(3);
    check("R5 4-pin deselected", sdo_oe, 0);
    sdi = 1'b0; tick(3);
    check("R5 4-pin selected", sdo_oe, 1);
    check("R9 4-pin sdo low", sdo, 0);
    conv_data = 16'hC3A5; conv_done = 1'b1; tick(1); conv_done = 1'b0;
    check("R6 4-pin start", sdo, 1);
    sck = 1'b1; tick(3); sck = 1'b0; tick(3);
    check("R6 msb after start", sdo, 1);
    sck = 1'b1; tick(3); sck = 1'b0; tick(3);
    check("R3 second bit", sdo, 1);
    sdi = 1'b1; tick(3);
    check("R5 4-pin release", sdo_oe, 0);

    // R10: done strobe while idle has no effect
    begin
      logic held;
      held = sdo;
      conv_data = ~16'hC3A5; conv_done = 1'b1; tick(1); conv_done = 1'b0; tick(2);
      check("R10 idle done sdo", sdo, held);
      check("R10 idle done busy", conv_busy, 0);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule